// File: doc/BRIEF.md
# Synchronous Rectifier Gate Controller

This block decides, clock by clock, whether the gate of a synchronous rectifier switch should be driven. It does not see analog voltages. It sees three comparator outcomes that have already been turned into digital flags. The turn-on flag means the drain-source voltage is well below zero, so the body diode is conducting. The turn-off flag means the voltage has risen to near zero. The rearm flag means the voltage has swung clearly positive. Besides these flags it takes an external SYNC signal that can force an early turn-off, an enable, and a supply-good indication. Two programmable counts set the minimum on time and the blanking period, both in clock cycles.

Every flag input is synchronised by two flops. Once the controller is running, it closes the switch as soon as conduction starts. It keeps the switch closed for at least the programmed minimum on time, even if ringing makes the turn-off flag assert early. It opens the switch when the turn-off flag is seen after that time. It then ignores new turn-on indications for the blanking period. A SYNC rising edge restarts both timers. If conduction ever ends before the minimum on time has passed, the controller stops driving the gate. It keeps timing each conduction interval and resumes driving once an interval lasts longer than the minimum.

Top module: `sr_gate_ctrl`

## Requirements
- R1: After a synchronous reset, `gate_o` is 0 and `mode_o` is 2'b00 (idle). The mode encoding is 2'b00 idle, 2'b01 normal and 2'b10 protection.
- R2: On entry to the running state, the controller stays idle with the gate low until the rearm flag is seen once. It then reports normal mode. This applies at start-up and after a supply-good or enable loss.
- R3: In normal mode, with SYNC low and no blanking active, a turn-on flag sets `gate_o` on the third rising clock edge after the flag is applied. That latency is two synchroniser stages plus the state register.
- R4: After a turn-on, the turn-off flag is ignored for max(`mot_cnt_i`,1) cycles. Once that time has elapsed, a turn-off flag clears the gate.
- R5: A comparator-driven turn-off starts a blanking window of `blank_cnt_i` cycles in which the turn-on flag is ignored. A rearm flag during the window ends it at once.
- R6: A high SYNC clears the gate regardless of the minimum on time and holds it low while high. A SYNC-driven turn-off starts no blanking.
- R7: A SYNC rising edge clears both the minimum-on-time timer and the blanking timer. A level that stays high has no further effect on them.
- R8: If the turn-off flag is already asserted when the minimum on time expires, the gate is cleared and the mode becomes protection. In protection mode, conduction intervals are timed but the gate is not driven.
- R9: In protection mode, a timed interval with the turn-off flag clear at expiry returns the mode to normal. The next conduction interval is then driven.
- R10: Loss of enable or supply-good clears the gate and returns the mode to idle. The controller must then be rearmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| on_flag_i | input | 1 | Comparator: drain-source below the turn-on level |
| off_flag_i | input | 1 | Comparator: drain-source above the turn-off level |
| rearm_flag_i | input | 1 | Comparator: drain-source above the positive rearm level |
| sync_i | input | 1 | External forced-off input; rising edge clears timers |
| en_i | input | 1 | Enable; low puts the block to sleep |
| pgood_i | input | 1 | Supply good |
| mot_cnt_i | input | MOT_W | Minimum on time in cycles (0 treated as 1) |
| blank_cnt_i | input | BLK_W | Blanking period in cycles |
| gate_o | output | 1 | Gate drive request |
| mode_o | output | 2 | 00 idle, 01 normal, 10 protection |

## Verification
The bench builds the controller with MOT_W=6 and BLK_W=7. It uses minimum on times of 1 to 15 cycles and blanking windows of 0 to 31 cycles. With these values a blanking window can run to its natural end within a short random stretch. Many full conduction cycles, protection entries and recoveries therefore occur alongside rearm- and SYNC-terminated windows. The directed part uses 10 and 40 cycles, so that the ignored-flag intervals are long enough to sample inside.

// File: rtl/srgc_pkg.sv
package srgc_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_RUN  = 2'b01,
    MODE_PROT = 2'b10
  } srgc_mode_e;
endpackage

// File: rtl/sr_flag_sync.sv
module sr_flag_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh[STAGES-1];
  end
endmodule

// File: rtl/sr_downcnt.sv
module sr_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] cnt;

  // load outranks clear: a turn-off and a rearm in one cycle still blank
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load_i)             cnt <= val_i;
    else if (clr_i)              cnt <= '0;
    else if (dec_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cnt_o  = cnt;
  assign zero_o = (cnt == '0);
  assign last_o = (cnt == W'(1));

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/sr_gate_ctrl.sv
module sr_gate_ctrl
  import srgc_pkg::*;
#(
  parameter int MOT_W       = 8,
  parameter int BLK_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_flag_i,
  input  logic             off_flag_i,
  input  logic             rearm_flag_i,
  input  logic             sync_i,
  input  logic             en_i,
  input  logic             pgood_i,
  input  logic [MOT_W-1:0] mot_cnt_i,
  input  logic [BLK_W-1:0] blank_cnt_i,
  output logic             gate_o,
  output logic [1:0]       mode_o
);
  localparam int NFLAG = 6;

  function automatic logic [MOT_W-1:0] mot_span(input logic [MOT_W-1:0] c);
    return (c == '0) ? MOT_W'(1) : c;
  endfunction

  logic [NFLAG-1:0] raw, syn;
  assign raw = {pgood_i, en_i, sync_i, rearm_flag_i, off_flag_i, on_flag_i};

  sr_flag_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(syn)
  );

  logic s_on, s_off, s_rearm, s_sync, run;
  assign s_on    = syn[0];
  assign s_off   = syn[1];
  assign s_rearm = syn[2];
  assign s_sync  = syn[3];
  assign run     = syn[5] & syn[4];

  srgc_mode_e mode_q, mode_d;
  logic gate_q, gate_d, cyc_q, cyc_d, sync_q;

  // named internal events
  logic armed, live, sync_rise, start_ev, expire_ev, trip_ev, end_ev;
  logic mot_zero, mot_last, blk_zero, blk_last;
  logic [MOT_W-1:0] mot_cnt;
  logic [BLK_W-1:0] blk_cnt;

  assign armed     = (mode_q != MODE_IDLE);
  assign live      = run & armed & ~s_sync;
  assign sync_rise = s_sync & ~sync_q;
  assign start_ev  = live & ~cyc_q & blk_zero & s_on;
  assign expire_ev = live & cyc_q & mot_last;
  assign trip_ev   = live & cyc_q & mot_zero & s_off;
  assign end_ev    = (expire_ev & (s_off | (mode_q == MODE_PROT))) | trip_ev;

  sr_downcnt #(.W(MOT_W)) u_mot (
    .clk(clk), .rst(rst),
    .clr_i(~run | s_sync | expire_ev),
    .load_i(start_ev), .val_i(mot_span(mot_cnt_i)),
    .dec_i(cyc_q),
    .cnt_o(mot_cnt), .zero_o(mot_zero), .last_o(mot_last)
  );

  sr_downcnt #(.W(BLK_W)) u_blk (
    .clk(clk), .rst(rst),
    .clr_i(~run | s_rearm | sync_rise),
    .load_i(end_ev), .val_i(blank_cnt_i),
    .dec_i(1'b1),
    .cnt_o(blk_cnt), .zero_o(blk_zero), .last_o(blk_last)
  );

  always_comb begin
    mode_d = mode_q;
    if (!run)                   mode_d = MODE_IDLE;
    else if (mode_q == MODE_IDLE) begin
      if (s_rearm)              mode_d = MODE_RUN;
    end else if (expire_ev)     mode_d = s_off ? MODE_PROT : MODE_RUN;
  end

  always_comb begin
    if (!run || s_sync)  cyc_d = 1'b0;
    else if (start_ev)   cyc_d = 1'b1;
    else if (end_ev)     cyc_d = 1'b0;
    else                 cyc_d = cyc_q;
  end

  always_comb begin
    if (!run || s_sync || end_ev) gate_d = 1'b0;
    else if (start_ev)            gate_d = (mode_q == MODE_RUN);
    else                          gate_d = gate_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      gate_q <= 1'b0;
      cyc_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      gate_q <= gate_d;
      cyc_q  <= cyc_d;
      sync_q <= s_sync;
    end
  end

  assign gate_o = gate_q;
  assign mode_o = mode_q;

  // R6
  sync_forces_off_chk: assert property (@(posedge clk) disable iff (rst)
    (run && s_sync) |=> !gate_q);
  // R10
  drop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!gate_q && mode_q == MODE_IDLE));
  // R2
  idle_no_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_IDLE) |-> !gate_q);
  // R8
  prot_no_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_PROT) |-> !gate_q);
  // R4
  mot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_q && run && !s_sync && !mot_zero && !mot_last) |=> gate_q);
  // R5
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cyc_q && !blk_zero) |=> !gate_q);
  // R7
  sync_rise_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sync_rise |=> (blk_zero && mot_zero));
  // R5
  blank_count_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_last && !end_ev) |=> blk_zero);
endmodule

// File: tb/sr_gate_ctrl_tb.sv
module sr_gate_ctrl_tb;
  localparam int MW = 6;
  localparam int BW = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, on_f = 1'b0, off_f = 1'b0, rs_f = 1'b0, sy = 1'b0, en = 1'b0, pg = 1'b0;
  logic [MW-1:0] mot = MW'(10);
  logic [BW-1:0] blk = BW'(40);
  logic gate;
  logic [1:0] mode;

  sr_gate_ctrl #(.MOT_W(MW), .BLK_W(BW)) u_dut (
    .clk(clk), .rst(rst), .on_flag_i(on_f), .off_flag_i(off_f),
    .rearm_flag_i(rs_f), .sync_i(sy), .en_i(en), .pgood_i(pg),
    .mot_cnt_i(mot), .blank_cnt_i(blk), .gate_o(gate), .mode_o(mode)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // cycle model written from the requirements: input vectors age two edges
  logic [5:0] p1 = '0, p2 = '0;
  logic m_sp = 1'b0, m_gate = 1'b0, m_cond = 1'b0, m_past = 1'b0;
  logic [1:0] m_mode = 2'b00;
  int m_age = 0, m_need = 1, m_bel = 0, m_blim = 0;

  always @(posedge clk) begin : model
    logic v_on, v_off, v_rs, v_sy, v_run, v_rise;
    if (rst) begin
      p1 = '0; p2 = '0; m_sp = 0; m_gate = 0; m_cond = 0; m_past = 0;
      m_mode = 2'b00; m_age = 0; m_bel = 0; m_blim = 0;
    end else begin
      v_on = p2[0]; v_off = p2[1]; v_rs = p2[2]; v_sy = p2[3];
      v_run = p2[4] & p2[5];
      v_rise = v_sy & ~m_sp;
      m_sp = v_sy;
      if (!v_run) begin
        m_mode = 2'b00; m_gate = 0; m_cond = 0; m_bel = 0; m_blim = 0;
      end else if (m_mode == 2'b00) begin
        if (v_rs) m_mode = 2'b01;
      end else if (v_sy) begin
        m_gate = 0; m_cond = 0;
        if (v_rise || v_rs) m_blim = 0;
        else if (m_bel < m_blim) m_bel++;
      end else if (m_cond) begin
        if (!m_past) begin
          m_age++;
          if (m_age == m_need) begin
            m_past = 1;
            if (v_off || m_mode == 2'b10) begin
              m_cond = 0; m_gate = 0; m_bel = 0; m_blim = int'(blk);
            end
            m_mode = v_off ? 2'b10 : 2'b01;
          end
        end else if (v_off) begin
          m_cond = 0; m_gate = 0; m_bel = 0; m_blim = int'(blk);
        end
      end else begin
        if (m_bel >= m_blim && v_on) begin
          m_cond = 1; m_past = 0; m_age = 0;
          m_need = (mot == '0) ? 1 : int'(mot);
          m_gate = (m_mode == 2'b01);
        end else if (v_rs) m_blim = 0;
        else if (m_bel < m_blim) m_bel++;
      end
      p2 = p1;
      p1 = {pg, en, sy, rs_f, off_f, on_f};
    end
  end

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R3 R4 R5 R6 R7 R8 R9 model gate", {1'b0, gate}, {1'b0, m_gate});
      check("R2 R8 R9 R10 model mode", mode, m_mode);
    end
  endtask

  task automatic rearm_pulse();
    rs_f = 1'b1; tick(1); rs_f = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R1 run incomplete)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(4);
    rst = 1'b0;
    tick(1);
    check("R1 reset gate", {1'b0, gate}, 2'b00);
    check("R1 reset mode", mode, 2'b00);

    en = 1; pg = 1; on_f = 1;
    tick(10);
    check("R2 unarmed gate", {1'b0, gate}, 2'b00);
    check("R2 unarmed mode", mode, 2'b00);
    on_f = 0; rearm_pulse(); tick(5);
    check("R2 armed mode", mode, 2'b01);

    on_f = 1; off_f = 1; tick(5);
    check("R3 turn-on", {1'b0, gate}, 2'b01);
    check("R4 off ignored within minimum", {1'b0, gate}, 2'b01);
    off_f = 0; tick(15);
    check("R4 still on", {1'b0, gate}, 2'b01);
    check("R4 mode normal", mode, 2'b01);
    off_f = 1; tick(4);
    check("R4 off after minimum", {1'b0, gate}, 2'b00);
    off_f = 0; tick(10);
    check("R5 blanked", {1'b0, gate}, 2'b00);
    rearm_pulse(); tick(5);
    check("R5 rearm ends blanking", {1'b0, gate}, 2'b01);

    sy = 1; tick(4);
    check("R6 sync overrides minimum", {1'b0, gate}, 2'b00);
    tick(10);
    check("R6 sync held off", {1'b0, gate}, 2'b00);
    sy = 0; tick(4);
    check("R6 no blanking after sync", {1'b0, gate}, 2'b01);
    tick(12); off_f = 1; tick(4);
    off_f = 0; tick(5);
    check("R5 blanked again", {1'b0, gate}, 2'b00);
    sy = 1; tick(3); sy = 0; tick(6);
    check("R7 sync edge clears blanking", {1'b0, gate}, 2'b01);

    tick(12); off_f = 1; on_f = 0; tick(4);
    rearm_pulse(); on_f = 1; tick(20);
    check("R8 protection mode", mode, 2'b10);
    check("R8 gate off", {1'b0, gate}, 2'b00);
    on_f = 0; off_f = 0; tick(3);
    rearm_pulse(); on_f = 1; tick(5);
    check("R8 pulse suppressed", {1'b0, gate}, 2'b00);
    check("R8 still protection", mode, 2'b10);
    tick(15);
    check("R9 recovered mode", mode, 2'b01);
    rearm_pulse(); tick(5);
    check("R9 gate driven again", {1'b0, gate}, 2'b01);

    en = 0; tick(4);
    check("R10 enable loss gate", {1'b0, gate}, 2'b00);
    check("R10 enable loss mode", mode, 2'b00);
    en = 1; tick(10);
    check("R2 rearm needed gate", {1'b0, gate}, 2'b00);
    rearm_pulse(); tick(5);
    check("R2 rearmed mode", mode, 2'b01);
    check("R3 on after rearm", {1'b0, gate}, 2'b01);
    pg = 0; tick(4);
    check("R10 supply loss gate", {1'b0, gate}, 2'b00);
    check("R10 supply loss mode", mode, 2'b00);
    pg = 1;

    for (int c = 0; c < 4000; c++) begin
      if (c % 250 == 0) begin
        mot = MW'(1 + $urandom % 15);
        blk = BW'($urandom % 32);
      end
      on_f  = ($urandom % 100) < 55;
      off_f = ($urandom % 100) < 35;
      rs_f  = ($urandom % 100) < 6;
      if (($urandom % 100) < 8) sy = ~sy;
      en = ($urandom % 200) != 0;
      pg = ($urandom % 300) != 0;
      tick(1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule